// File: doc/BRIEF.md
# Instruction Decoder and PC Sequencer

This block sits at the front of a small 8-bit core with a 16-bit instruction word. The word currently addressed by the program counter is decoded in the same cycle it is presented. From it the block extracts destination and source register indices, an 8-bit immediate and an ALU operation code, and it raises a register write-enable. It also computes the address of the following instruction in word units. Encodings outside the supported subset decode as a no-operation.

Control flow is computed here. A relative jump adds a sign-extended 12-bit offset plus one to the PC. A conditional branch tests one selected bit of the status byte and, when that bit is set, adds a sign-extended 7-bit offset plus one. The two bit-test-and-skip forms raise a skip request. The surrounding pipeline returns that request as the squash input while the next word is presented. A squashed word has no effect except that the PC moves by one.

The PC register advances to the computed next PC on each clock where the step enable is high. The register file is outside this block. It supplies the tested bit for the skip forms, taken from the register at the source index and the bit position in the low three immediate bits.

Top module: `idec_core`

## Requirements
- R1: While reset is asserted, and until two clock edges after it is released, `pc_o` is 0. After that, `pc_o` loads `next_pc_o` on each rising edge where `step_i` is 1, and holds its value where `step_i` is 0.
- R2: For ADD (`000011rdddddrrrr`) and MOV (`001011rdddddrrrr`), `rd_idx_o`={bit8,bits7:4}, `rr_idx_o`={bit9,bits3:0}, `wr_en_o`=1, and `alu_op_o` is 1 for ADD and 4 for MOV.
- R3: For AND-immediate (`0111KKKKddddKKKK`, op 2) and load-immediate (`1110KKKKddddKKKK`, op 5), `rd_idx_o`=16+bits7:4, `imm_o`={bits11:8,bits3:0}, `wr_en_o`=1.
- R4: For arithmetic shift right (`1001010ddddd0101`), `rd_idx_o`=bits8:4, `alu_op_o`=3, `wr_en_o`=1.
- R5: With no jump, taken branch or squash, `next_pc_o`=`pc_o`+1, modulo 2^PC_W.
- R6: For the relative jump (`1100kkkkkkkkkkkk`), `next_pc_o`=`pc_o`+sext(k)+1 modulo 2^PC_W, with k from -2048 to +2047, and `wr_en_o`=0.
- R7: For the conditional branch (`111100kkkkkkksss`), `next_pc_o`=`pc_o`+sext(k)+1 when status bit s is 1, else `pc_o`+1. Status bits: 0 carry, 1 zero, 3 overflow, 4 sign. The encodings tested are equal (s=1), less-than (s=4) and overflow (s=3).
- R8: For skip-if-clear (`1111110rrrrr0bbb`) and skip-if-set (`1111111rrrrr0bbb`), `rr_idx_o`=bits8:4 and `imm_o`=bits2:0. `skip_o` is 1 when `test_bit_i` is 0 (clear form) or 1 (set form), else 0. `wr_en_o` is 0.
- R9: While `squash_i` is 1, `wr_en_o`=0, `alu_op_o`=0 and `skip_o`=0, and `next_pc_o`=`pc_o`+1, whatever the word.
- R10: Any other encoding gives `alu_op_o`=0, `wr_en_o`=0, `skip_o`=0 and `next_pc_o`=`pc_o`+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | PC advance enable |
| instr_i | input | 16 | Instruction word at `pc_o` |
| sreg_i | input | 8 | Status byte |
| test_bit_i | input | 1 | Tested register bit for skip forms |
| squash_i | input | 1 | Current word is being skipped |
| rd_idx_o | output | 5 | Destination register index |
| rr_idx_o | output | 5 | Source register index |
| imm_o | output | 8 | Immediate / tested bit position |
| alu_op_o | output | 3 | ALU operation code |
| wr_en_o | output | 1 | Register write enable |
| skip_o | output | 1 | Request to skip the following word |
| pc_o | output | PC_W | Current program counter (words) |
| next_pc_o | output | PC_W | Next program counter (words) |

## Verification
Jumps go to both ends of the 12-bit range and to a negative target that wraps below address zero. A design that zero-extends the offset or drops the +1 lands at the wrong word. Branches run backward with the selected flag set, and forward with only a different flag set. A decoder that picks the wrong status bit then branches where it should fall through. The immediate forms use destination nibbles that show whether bit 4 is forced high and whether the constant halves end up in the right order. Squashed jumps, writes and skips confirm that a skipped word changes nothing but the PC.

// File: rtl/idec_pkg.sv
package idec_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ADD = 3'd1,
    OP_AND = 3'd2,
    OP_ASR = 3'd3,
    OP_MOV = 3'd4,
    OP_LDI = 3'd5
  } alu_op_e;

  typedef enum logic [2:0] {
    FL_SEQ  = 3'd0,
    FL_JMP  = 3'd1,
    FL_BR   = 3'd2,
    FL_SKC  = 3'd3,
    FL_SKS  = 3'd4
  } flow_e;

  localparam int unsigned OFF_W = 12;
endpackage

// File: rtl/idec_fields.sv
module idec_fields
  import idec_pkg::*;
(
  input  logic [15:0]       instr_i,
  output alu_op_e           op_o,
  output flow_e             flow_o,
  output logic [4:0]        rd_o,
  output logic [4:0]        rr_o,
  output logic [7:0]        imm_o,
  output logic              wr_o,
  output logic [2:0]        sel_o,
  output logic [OFF_W-1:0]  off_o
);
  localparam int unsigned BR_W = 7;

  always_comb begin
    op_o   = OP_NOP;
    flow_o = FL_SEQ;
    rd_o   = 5'd0;
    rr_o   = 5'd0;
    imm_o  = 8'd0;
    wr_o   = 1'b0;
    sel_o  = instr_i[2:0];
    off_o  = '0;
    casez (instr_i)
      16'b0000_11??_????_????: begin
        op_o = OP_ADD;
        rd_o = {instr_i[8], instr_i[7:4]};
        rr_o = {instr_i[9], instr_i[3:0]};
        wr_o = 1'b1;
      end
      16'b0010_11??_????_????: begin
        op_o = OP_MOV;
        rd_o = {instr_i[8], instr_i[7:4]};
        rr_o = {instr_i[9], instr_i[3:0]};
        wr_o = 1'b1;
      end
      16'b0111_????_????_????: begin
        op_o  = OP_AND;
        rd_o  = {1'b1, instr_i[7:4]};
        imm_o = {instr_i[11:8], instr_i[3:0]};
        wr_o  = 1'b1;
      end
      16'b1110_????_????_????: begin
        op_o  = OP_LDI;
        rd_o  = {1'b1, instr_i[7:4]};
        imm_o = {instr_i[11:8], instr_i[3:0]};
        wr_o  = 1'b1;
      end
      16'b1001_010?_????_0101: begin
        op_o = OP_ASR;
        rd_o = instr_i[8:4];
        wr_o = 1'b1;
      end
      16'b1100_????_????_????: begin
        flow_o = FL_JMP;
        off_o  = instr_i[OFF_W-1:0];
      end
      16'b1111_00??_????_????: begin
        flow_o = FL_BR;
        off_o  = {{(OFF_W-BR_W){instr_i[9]}}, instr_i[9:3]};
      end
      16'b1111_110?_????_0???: begin
        flow_o = FL_SKC;
        rr_o   = instr_i[8:4];
        imm_o  = {5'd0, instr_i[2:0]};
      end
      16'b1111_111?_????_0???: begin
        flow_o = FL_SKS;
        rr_o   = instr_i[8:4];
        imm_o  = {5'd0, instr_i[2:0]};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/idec_flow.sv
module idec_flow
  import idec_pkg::*;
#(
  parameter int unsigned PC_W = 16
) (
  input  logic [PC_W-1:0]   pc_i,
  input  flow_e             flow_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [2:0]        sel_i,
  input  logic [7:0]        sreg_i,
  input  logic              test_bit_i,
  input  logic              squash_i,
  output logic [PC_W-1:0]   next_pc_o,
  output logic              skip_o
);
  localparam int unsigned EXT_W = PC_W - OFF_W;

  logic [PC_W-1:0] off_ext;
  logic [PC_W-1:0] base;
  logic            take;

  assign off_ext = {{EXT_W{off_i[OFF_W-1]}}, off_i};
  assign base    = pc_i + PC_W'(1);

  always_comb begin
    take   = 1'b0;
    skip_o = 1'b0;
    if (!squash_i) begin
      unique case (flow_i)
        FL_JMP:  take = 1'b1;
        FL_BR:   take = sreg_i[sel_i];
        FL_SKC:  skip_o = ~test_bit_i;
        FL_SKS:  skip_o = test_bit_i;
        default: ;
      endcase
    end
    next_pc_o = take ? (base + off_ext) : base;
  end
endmodule

// File: rtl/idec_core.sv
module idec_core
  import idec_pkg::*;
#(
  parameter int unsigned PC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic [15:0]      instr_i,
  input  logic [7:0]       sreg_i,
  input  logic             test_bit_i,
  input  logic             squash_i,
  output logic [4:0]       rd_idx_o,
  output logic [4:0]       rr_idx_o,
  output logic [7:0]       imm_o,
  output logic [2:0]       alu_op_o,
  output logic             wr_en_o,
  output logic             skip_o,
  output logic [PC_W-1:0]  pc_o,
  output logic [PC_W-1:0]  next_pc_o
);
  logic [1:0]       rst_pipe;
  logic             rst_q;
  logic [PC_W-1:0]  pc_q;
  logic [PC_W-1:0]  pc_d;
  alu_op_e          dec_op;
  flow_e            dec_flow;
  logic             dec_wr;
  logic [2:0]       dec_sel;
  logic [OFF_W-1:0] dec_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  idec_fields u_fields (
    .instr_i (instr_i),
    .op_o    (dec_op),
    .flow_o  (dec_flow),
    .rd_o    (rd_idx_o),
    .rr_o    (rr_idx_o),
    .imm_o   (imm_o),
    .wr_o    (dec_wr),
    .sel_o   (dec_sel),
    .off_o   (dec_off)
  );

  idec_flow #(.PC_W(PC_W)) u_flow (
    .pc_i       (pc_q),
    .flow_i     (dec_flow),
    .off_i      (dec_off),
    .sel_i      (dec_sel),
    .sreg_i     (sreg_i),
    .test_bit_i (test_bit_i),
    .squash_i   (squash_i),
    .next_pc_o  (next_pc_o),
    .skip_o     (skip_o)
  );

  assign wr_en_o  = dec_wr & ~squash_i;
  assign alu_op_o = squash_i ? OP_NOP : dec_op;

  always_comb begin
    pc_d = pc_q;
    if (step_i) pc_d = next_pc_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc_q <= '0;
    else if (!rst_q) pc_q <= '0;
    else             pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/idec_core_chk.sv
module idec_core_chk #(
  parameter int unsigned PC_W = 16
) (
  input logic            clk,
  input logic            rst_q,
  input logic            step_i,
  input logic            squash_i,
  input logic [2:0]      alu_op_o,
  input logic [4:0]      rd_idx_o,
  input logic            wr_en_o,
  input logic            skip_o,
  input logic [PC_W-1:0] pc_o,
  input logic [PC_W-1:0] next_pc_o
);
  AST_PC_LOAD: assert property (@(posedge clk) disable iff (!rst_q)
    step_i |=> (pc_o == $past(next_pc_o))); // R1

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
    !step_i |=> $stable(pc_o)); // R1

  AST_SQUASH_INERT: assert property (@(posedge clk) disable iff (!rst_q)
    squash_i |-> (!wr_en_o && !skip_o && alu_op_o == 3'd0
                  && next_pc_o == PC_W'(pc_o + 1'b1))); // R9

  AST_IMM_UPPER: assert property (@(posedge clk) disable iff (!rst_q)
    (alu_op_o == 3'd2 || alu_op_o == 3'd5) |-> rd_idx_o[4]); // R3

  AST_SKIP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_q)
    skip_o |-> (!wr_en_o && next_pc_o == PC_W'(pc_o + 1'b1))); // R8

  AST_NOP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_q)
    (alu_op_o == 3'd0) |-> !wr_en_o); // R10
endmodule

bind idec_core idec_core_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/test_idec_core.sv
module test_idec_core;
  localparam int PC_W = 16;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            step_i;
  logic [15:0]     instr_i;
  logic [7:0]      sreg_i;
  logic            test_bit_i;
  logic            squash_i;
  logic [4:0]      rd_idx_o;
  logic [4:0]      rr_idx_o;
  logic [7:0]      imm_o;
  logic [2:0]      alu_op_o;
  logic            wr_en_o;
  logic            skip_o;
  logic [PC_W-1:0] pc_o;
  logic [PC_W-1:0] next_pc_o;

  int checks = 0;
  int errors = 0;
  logic [PC_W-1:0] exp_pc;

  always #5 clk = ~clk;

  idec_core #(.PC_W(PC_W)) i_idec_core (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .instr_i(instr_i),
    .sreg_i(sreg_i), .test_bit_i(test_bit_i), .squash_i(squash_i),
    .rd_idx_o(rd_idx_o), .rr_idx_o(rr_idx_o), .imm_o(imm_o),
    .alu_op_o(alu_op_o), .wr_en_o(wr_en_o), .skip_o(skip_o),
    .pc_o(pc_o), .next_pc_o(next_pc_o)
  );

  function automatic logic [15:0] enc_rr(input logic [5:0] opc, input logic [4:0] d, input logic [4:0] r);
    return {opc, r[4], d[4], d[3:0], r[3:0]};
  endfunction
  function automatic logic [15:0] enc_ri(input logic [3:0] opc, input logic [3:0] d, input logic [7:0] k);
    return {opc, k[7:4], d, k[3:0]};
  endfunction
  function automatic logic [15:0] enc_jmp(input logic [11:0] k);
    return {4'b1100, k};
  endfunction
  function automatic logic [15:0] enc_br(input logic [2:0] s, input logic [6:0] k);
    return {6'b111100, k, s};
  endfunction
  function automatic logic [15:0] enc_sk(input logic set, input logic [4:0] r, input logic [2:0] b);
    return {6'b111111, set, r, 1'b0, b};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] w, input logic [7:0] s, input logic tb, input logic sq);
    @(negedge clk);
    instr_i = w; sreg_i = s; test_bit_i = tb; squash_i = sq;
    #1;
  endtask

  task automatic do_step();
    exp_pc = next_pc_o;
    step_i = 1'b1;
    @(posedge clk);
    #1;
    step_i = 1'b0;
    check("R1 pc after step", pc_o, exp_pc);
  endtask

  task automatic goto_pc(input logic [PC_W-1:0] tgt);
    logic [PC_W-1:0] off;
    off = tgt - pc_o - 16'd1;
    drive(enc_jmp(off[11:0]), 8'h00, 1'b0, 1'b0);
    do_step();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; step_i = 1'b0; instr_i = 16'h0000; sreg_i = 8'h00;
    test_bit_i = 1'b0; squash_i = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 pc in reset", pc_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 pc after release", pc_o, 0);
  endtask

  task automatic t_hold();
    drive(16'h0000, 8'h00, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    #1;
    check("R1 pc holds without step", pc_o, 0);
    check("R5 sequential next", next_pc_o, 1);
    do_step();
  endtask

  task automatic t_rr();
    drive(enc_rr(6'b000011, 5'd17, 5'd3), 8'h00, 1'b0, 1'b0);
    check("R2 add rd", rd_idx_o, 17);
    check("R2 add rr", rr_idx_o, 3);
    check("R2 add op", alu_op_o, 1);
    check("R2 add wr", wr_en_o, 1);
    drive(enc_rr(6'b001011, 5'd2, 5'd30), 8'h00, 1'b0, 1'b0);
    check("R2 mov rd", rd_idx_o, 2);
    check("R2 mov rr", rr_idx_o, 30);
    check("R2 mov op", alu_op_o, 4);
    check("R5 mov next", next_pc_o, pc_o + 16'd1);
  endtask

  task automatic t_imm();
    drive(enc_ri(4'b0111, 4'h5, 8'hA3), 8'h00, 1'b0, 1'b0);
    check("R3 andi rd", rd_idx_o, 21);
    check("R3 andi imm", imm_o, 8'hA3);
    check("R3 andi op", alu_op_o, 2);
    check("R3 andi wr", wr_en_o, 1);
    drive(enc_ri(4'b1110, 4'h0, 8'h3C), 8'h00, 1'b0, 1'b0);
    check("R3 ldi rd", rd_idx_o, 16);
    check("R3 ldi imm", imm_o, 8'h3C);
    check("R3 ldi op", alu_op_o, 5);
  endtask

  task automatic t_asr();
    drive({7'b1001010, 5'd27, 4'b0101}, 8'h00, 1'b0, 1'b0);
    check("R4 asr rd", rd_idx_o, 27);
    check("R4 asr op", alu_op_o, 3);
    check("R4 asr wr", wr_en_o, 1);
  endtask

  task automatic t_jump();
    goto_pc(16'h0000);
    drive(enc_jmp(12'h7FF), 8'h00, 1'b0, 1'b0);
    check("R6 jmp max", next_pc_o, 16'h0800);
    check("R6 jmp no wr", wr_en_o, 0);
    drive(enc_jmp(12'h800), 8'h00, 1'b0, 1'b0);
    check("R6 jmp min wraps", next_pc_o, 16'hF801);
    drive(enc_jmp(12'hFFF), 8'h00, 1'b0, 1'b0);
    check("R6 jmp minus one", next_pc_o, 16'h0000);
    drive(enc_jmp(12'd40), 8'h00, 1'b0, 1'b0);
    do_step();
    check("R6 jmp landed", pc_o, 16'd41);
  endtask

  task automatic t_branch();
    goto_pc(16'h0100);
    drive(enc_br(3'd1, 7'd5), 8'h02, 1'b0, 1'b0);
    check("R7 breq taken", next_pc_o, 16'h0106);
    drive(enc_br(3'd1, 7'd5), 8'hFD, 1'b0, 1'b0);
    check("R7 breq not taken", next_pc_o, 16'h0101);
    drive(enc_br(3'd4, 7'h40), 8'h10, 1'b0, 1'b0);
    check("R7 brlt back", next_pc_o, 16'h00C1);
    drive(enc_br(3'd3, 7'h10), 8'h10, 1'b0, 1'b0);
    check("R7 brvs other flag", next_pc_o, 16'h0101);
    drive(enc_br(3'd3, 7'h10), 8'h08, 1'b0, 1'b0);
    check("R7 brvs taken", next_pc_o, 16'h0111);
    do_step();
  endtask

  task automatic t_skip();
    drive(enc_sk(1'b0, 5'd9, 3'd6), 8'h00, 1'b0, 1'b0);
    check("R8 sbrc rr", rr_idx_o, 9);
    check("R8 sbrc bit", imm_o, 6);
    check("R8 sbrc skip", skip_o, 1);
    check("R8 sbrc no wr", wr_en_o, 0);
    drive(enc_sk(1'b0, 5'd9, 3'd6), 8'h00, 1'b1, 1'b0);
    check("R8 sbrc no skip", skip_o, 0);
    drive(enc_sk(1'b1, 5'd31, 3'd0), 8'h00, 1'b1, 1'b0);
    check("R8 sbrs skip", skip_o, 1);
    check("R8 sbrs rr", rr_idx_o, 31);
    drive(enc_sk(1'b1, 5'd31, 3'd0), 8'h00, 1'b0, 1'b0);
    check("R8 sbrs no skip", skip_o, 0);
  endtask

  task automatic t_squash();
    drive(enc_rr(6'b000011, 5'd4, 5'd5), 8'h00, 1'b0, 1'b1);
    check("R9 squash wr", wr_en_o, 0);
    check("R9 squash op", alu_op_o, 0);
    drive(enc_jmp(12'd100), 8'h00, 1'b0, 1'b1);
    check("R9 squash jmp", next_pc_o, pc_o + 16'd1);
    drive(enc_br(3'd1, 7'd9), 8'hFF, 1'b0, 1'b1);
    check("R9 squash br", next_pc_o, pc_o + 16'd1);
    drive(enc_sk(1'b0, 5'd1, 3'd1), 8'h00, 1'b0, 1'b1);
    check("R9 squash skip", skip_o, 0);
    do_step();
  endtask

  task automatic t_unknown();
    drive(16'hFFFF, 8'hFF, 1'b1, 1'b0);
    check("R10 unk op", alu_op_o, 0);
    check("R10 unk wr", wr_en_o, 0);
    check("R10 unk skip", skip_o, 0);
    check("R10 unk next", next_pc_o, pc_o + 16'd1);
    drive(16'hF400, 8'hFF, 1'b0, 1'b0);
    check("R10 unk2 next", next_pc_o, pc_o + 16'd1);
    check("R10 unk2 wr", wr_en_o, 0);
  endtask

  initial begin
    t_reset();
    t_hold();
    t_rr();
    t_imm();
    t_asr();
    t_jump();
    t_branch();
    t_skip();
    t_squash();
    t_unknown();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule